// File: doc/BRIEF.md
# Single-Wire Pattern Programming Transmitter

This block sits on the host side of an isolated line-interface board. It takes a six-bit output pattern and turns it into the timed logic-level waveform that a self-timed serial decoder on the far side of an optical barrier understands. That decoder has no clock of its own. It recovers each bit from how long the line stays high after a rising edge. The transmitter therefore sends every bit as a fixed low setup interval followed by a high pulse. A long pulse encodes a one. A short pulse followed by a long low interval encodes a zero.

A single-cycle `start` launches a transfer, and the pattern is captured on that same edge. All six bits are always sent, least significant bit first. `busy` is high for the whole transfer, and `done` pulses once when it completes. Every duration is a parameter counted in ticks of an external enable, normally one per microsecond. The default values are 50 ticks for the setup low, 200 ticks for a one-high, 50 ticks for a zero-high and 150 ticks for a zero-low. After the last bit the line is left low.

Top module: `spt_wave_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, `line_out`, `busy` and `done` are all low.
- R2: `start` is taken only while `busy` is low, and `pattern` is captured on that edge. `start` pulses and `pattern` changes made while `busy` is high do not alter the transfer in progress.
- R3: Every bit begins with `line_out` low for exactly SETUP_TICKS ticks.
- R4: A bit of value 1 is sent as `line_out` high for exactly ONE_HIGH_TICKS ticks, directly after its setup interval.
- R5: A bit of value 0 is sent as `line_out` high for exactly ZERO_HIGH_TICKS ticks, then low for exactly ZERO_LOW_TICKS ticks.
- R6: Bits go out in order `pattern[0]` first to `pattern[5]` last, and all six are always sent.
- R7: `busy` is high from the cycle after the accepted `start` until the final interval ends. `done` is high for exactly one cycle per transfer, in the first cycle in which `busy` is low again.
- R8: Whenever `busy` is low, `line_out` is low, and it stays low after a transfer ends.
- R9: Time advances only on cycles where `tick_en` is high. A phase lasts a fixed number of ticks whatever the spacing between them, and `line_out` does not change on a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base enable, one cycle per tick |
| start | input | 1 | Request to send `pattern` |
| pattern | input | WIDTH (6) | Output pattern, bit 0 sent first |
| line_out | output | 1 | Serial programming line (logic level) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The bench rebuilds the line level seen at every tick of a transfer and compares it sample by sample with a waveform computed from the pattern. A phase that is one tick short or long therefore shows up at once, as does a zero bit sent without its trailing low or a word sent most significant bit first. Tick spacing is varied, and ticks are withheld in the middle of a transfer, to catch a timer that counts clock cycles instead of ticks. A second `start` and a changed pattern are applied in mid-transfer; a design that restarted or re-sampled the pattern would emit a different waveform. All-zero and all-one patterns check the ending on a zero bit and on a one bit, where a wrong design would leave the line high or send `done` early or twice.

// File: rtl/spt_pkg.sv
// Package: shared phase encoding for the single-wire pattern transmitter.
// Assumes: nothing beyond being compiled before the modules that import it.
package spt_pkg;

    // Phase of the transmitter; the line is high only in SPT_HIGH.
    typedef enum logic [1:0] {
        SPT_IDLE  = 2'd0,
        SPT_SETUP = 2'd1,
        SPT_HIGH  = 2'd2,
        SPT_TAIL  = 2'd3
    } spt_phase_e;

endpackage

// File: rtl/spt_phase_timer.sv
// Module: spt_phase_timer
// Counts tick enables inside one phase and flags the tick that ends it.
// Assumes: limit >= 1 and held steady through a phase; clear is high in idle.
// The count restarts at every phase end, so each phase lasts exactly limit ticks.
module spt_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Phase ends on the tick that completes the limit-th count.
    assign expire = tick_en && !clear && (cnt_q == (limit - 1'b1));

    // Tick counter: cleared in idle and at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || expire) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The count never reaches the limit of the running phase.
    a_r9_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < limit));

    // Without a tick the count holds (time does not advance).
    a_r9_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/spt_bit_queue.sv
// Module: spt_bit_queue
// Holds the captured pattern and presents the bit currently being sent.
// Assumes: load only while idle; advance once per finished bit, never on the last.
module spt_bit_queue #(
    parameter int WIDTH = 6,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             advance,
    output logic             cur_bit,
    output logic             last_bit
);

    logic [WIDTH-1:0] data_q;
    logic [IDX_W-1:0] idx_q;

    assign cur_bit  = data_q[0];
    assign last_bit = (idx_q == IDX_W'(WIDTH - 1));

    // Capture on load, shift right by one after each bit (LSB first).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            data_q <= load_data;
            idx_q  <= '0;
        end else if (advance) begin
            data_q <= data_q >> 1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Index of the bit in flight stays inside the word.
    a_r6_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(WIDTH - 1));

    // No advance past the last bit.
    a_r6_no_advance_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last_bit);

endmodule

// File: rtl/spt_wave_tx.sv
// Module: spt_wave_tx (top)
// Sends a WIDTH-bit pattern on one wire, LSB first. Each bit is a low setup
// interval followed by a high pulse: long for one, short plus a long low for zero.
// Assumes: tick_en is a one-cycle enable at the desired time base; all tick
// parameters are >= 1. The line is low whenever the block is idle.
module spt_wave_tx
    import spt_pkg::*;
#(
    parameter int WIDTH           = 6,
    parameter int SETUP_TICKS     = 50,
    parameter int ONE_HIGH_TICKS  = 200,
    parameter int ZERO_HIGH_TICKS = 50,
    parameter int ZERO_LOW_TICKS  = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic [WIDTH-1:0] pattern,
    output logic             line_out,
    output logic             busy,
    output logic             done
);

    localparam int MAX_A = (SETUP_TICKS > ONE_HIGH_TICKS) ? SETUP_TICKS : ONE_HIGH_TICKS;
    localparam int MAX_B = (ZERO_HIGH_TICKS > ZERO_LOW_TICKS) ? ZERO_HIGH_TICKS : ZERO_LOW_TICKS;
    localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_TICKS + 1);

    spt_phase_e       phase_q, phase_d;
    logic             done_q;
    logic             accept;
    logic             expire;
    logic             cur_bit;
    logic             last_bit;
    logic             advance;
    logic             finish;
    logic [CNT_W-1:0] limit;

    assign accept   = (phase_q == SPT_IDLE) && start;
    assign busy     = (phase_q != SPT_IDLE);
    assign line_out = (phase_q == SPT_HIGH);
    assign done     = done_q;

    // Length of the current phase in ticks.
    always_comb begin
        unique case (phase_q)
            SPT_SETUP: limit = CNT_W'(SETUP_TICKS);
            SPT_HIGH:  limit = cur_bit ? CNT_W'(ONE_HIGH_TICKS) : CNT_W'(ZERO_HIGH_TICKS);
            SPT_TAIL:  limit = CNT_W'(ZERO_LOW_TICKS);
            default:   limit = CNT_W'(SETUP_TICKS);
        endcase
    end

    // Phase sequencing: setup, high, and for zero bits a trailing low.
    always_comb begin
        phase_d = phase_q;
        advance = 1'b0;
        finish  = 1'b0;
        unique case (phase_q)
            SPT_IDLE: begin
                if (accept) phase_d = SPT_SETUP;
            end
            SPT_SETUP: begin
                if (expire) phase_d = SPT_HIGH;
            end
            SPT_HIGH: begin
                if (expire) begin
                    if (!cur_bit) begin
                        phase_d = SPT_TAIL;
                    end else if (last_bit) begin
                        phase_d = SPT_IDLE;
                        finish  = 1'b1;
                    end else begin
                        phase_d = SPT_SETUP;
                        advance = 1'b1;
                    end
                end
            end
            SPT_TAIL: begin
                if (expire) begin
                    if (last_bit) begin
                        phase_d = SPT_IDLE;
                        finish  = 1'b1;
                    end else begin
                        phase_d = SPT_SETUP;
                        advance = 1'b1;
                    end
                end
            end
            default: phase_d = SPT_IDLE;
        endcase
    end

    // Phase register and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SPT_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish;
        end
    end

    spt_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clear   (phase_q == SPT_IDLE),
        .limit   (limit),
        .expire  (expire)
    );

    spt_bit_queue #(
        .WIDTH (WIDTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (pattern),
        .advance   (advance),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit)
    );

    // Busy rises only from an idle cycle that saw start.
    a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // Done is a single-cycle pulse.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done appears exactly as busy falls.
    a_r7_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // Each rising edge of the line follows a setup interval.
    a_r3_rise_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_out) |-> ($past(phase_q) == SPT_SETUP));

    // Line low when not busy.
    a_r8_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_out);

    // No tick, no line change.
    a_r9_line_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> $stable(line_out));

endmodule

// File: tb/spt_wave_tx_tb.sv
// Bench for spt_wave_tx: table of patterns and tick spacings walked by one
// loop, then directed tests for reset, mid-transfer start and tick stalls.
module spt_wave_tx_tb;

    localparam int W    = 6;
    localparam int TS   = 3;
    localparam int T1   = 8;
    localparam int T0H  = 2;
    localparam int T0L  = 7;
    localparam int NVEC = 8;
    localparam int BUFN = 256;

    // {pattern[5:0], tick spacing[2:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {6'b010100, 3'd1},
        {6'b011100, 3'd2},
        {6'b000000, 3'd1},
        {6'b111111, 3'd1},
        {6'b100000, 3'd3},
        {6'b000001, 3'd2},
        {6'b101010, 3'd1},
        {6'b010101, 3'd4}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] pattern = '0;
    logic         line_out;
    logic         busy;
    logic         done;

    int checks = 0;
    int errors = 0;
    int tdiv = 1;
    int tcnt = 0;
    bit tick_hold = 1'b0;
    bit rec_on = 1'b0;
    int rec_n = 0;
    int done_cnt = 0;
    logic rec_buf [BUFN];
    logic exp_buf [BUFN];
    int exp_n = 0;

    always #5 clk = ~clk;

    spt_wave_tx #(
        .WIDTH           (W),
        .SETUP_TICKS     (TS),
        .ONE_HIGH_TICKS  (T1),
        .ZERO_HIGH_TICKS (T0H),
        .ZERO_LOW_TICKS  (T0L)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .start    (start),
        .pattern  (pattern),
        .line_out (line_out),
        .busy     (busy),
        .done     (done)
    );

    // Tick generator, driven just after the rising edge.
    always @(posedge clk) begin
        #2;
        if (tick_hold) begin
            tick_en = 1'b0;
        end else begin
            tick_en = (tcnt == 0);
            tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
        end
    end

    // Recorder: line level at every tick while busy, and done pulses.
    always @(negedge clk) begin
        if (rec_on) begin
            if (busy && tick_en) begin
                if (rec_n < BUFN) rec_buf[rec_n] = line_out;
                rec_n++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected waveform from R3..R6: per bit, setup low, then one/zero coding.
    task automatic build_exp(input logic [W-1:0] pat);
        exp_n = 0;
        for (int b = 0; b < W; b++) begin
            for (int k = 0; k < TS; k++) begin exp_buf[exp_n] = 1'b0; exp_n++; end
            if (pat[b]) begin
                for (int k = 0; k < T1; k++) begin exp_buf[exp_n] = 1'b1; exp_n++; end
            end else begin
                for (int k = 0; k < T0H; k++) begin exp_buf[exp_n] = 1'b1; exp_n++; end
                for (int k = 0; k < T0L; k++) begin exp_buf[exp_n] = 1'b0; exp_n++; end
            end
        end
    endtask

    task automatic pulse_start(input logic [W-1:0] pat);
        @(posedge clk); #2;
        start = 1'b1;
        pattern = pat;
        @(posedge clk); #2;
        start = 1'b0;
        pattern = ~pat;   // R2: later pattern changes must not matter
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Compare recorded line samples with the expected waveform.
    task automatic compare_wave(input string req);
        int bad = 0;
        int first = -1;
        check(rec_n == exp_n, req, rec_n, exp_n);
        for (int i = 0; i < exp_n && i < rec_n; i++) begin
            if (rec_buf[i] !== exp_buf[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, req, first, -1);
    endtask

    task automatic after_checks();
        int hi = 0;
        check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        check(busy == 1'b0, "R7 busy after end", int'(busy), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (line_out !== 1'b0) hi++;
        end
        check(hi == 0, "R8 line low after end", hi, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 in reset",
              int'({line_out, busy, done}), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 after reset",
              int'({line_out, busy, done}), 0);

        // R3 R4 R5 R6 R7 R8 R9: table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [W-1:0] pat;
            pat = VEC[v][8:3];
            tdiv = int'(VEC[v][2:0]);
            build_exp(pat);
            rec_n = 0;
            done_cnt = 0;
            rec_on = 1'b1;
            pulse_start(pat);
            wait_done();
            rec_on = 1'b0;
            compare_wave("R6 waveform (R3 R4 R5 R9)");
            after_checks();
        end

        // R2: second start and pattern change mid-transfer are ignored
        tdiv = 1;
        build_exp(6'b001011);
        rec_n = 0;
        done_cnt = 0;
        rec_on = 1'b1;
        pulse_start(6'b001011);
        repeat (30) @(posedge clk);
        #2;
        start = 1'b1;
        pattern = 6'b110100;
        @(posedge clk); #2;
        start = 1'b0;
        wait_done();
        rec_on = 1'b0;
        compare_wave("R2 restart ignored");
        after_checks();

        // R9: ticks withheld mid-transfer freeze the line
        begin
            int moved = 0;
            logic held;
            tdiv = 1;
            build_exp(6'b110010);
            rec_n = 0;
            done_cnt = 0;
            rec_on = 1'b1;
            pulse_start(6'b110010);
            repeat (25) @(posedge clk);
            #3;
            tick_hold = 1'b1;
            @(negedge clk);
            @(negedge clk);
            held = line_out;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (line_out !== held || busy !== 1'b1) moved++;
            end
            check(moved == 0, "R9 stall holds line", moved, 0);
            @(posedge clk); #3;
            tick_hold = 1'b0;
            wait_done();
            rec_on = 1'b0;
            compare_wave("R9 waveform after stall");
            after_checks();
        end

        // R1: reset in mid-transfer returns to the idle state
        tdiv = 1;
        pulse_start(6'b111111);
        repeat (20) @(posedge clk);
        #2;
        rst_n = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 mid-run reset",
              int'({line_out, busy, done}), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule